// File: doc/BRIEF.md
# Frame Header Fetch and Geometry Sequencer

This block runs once per display frame inside an LCD controller. When a frame begins it reads the first 16-bit word of the active frame buffer. That word is a header whose depth field sets the number of bits per pixel. From the depth, the palette-load mode and the panel geometry, the block computes:

- the byte address where pixel data begins,
- the number of bytes in one line,
- the range of lines to show,
- the address of the first line to show.

Before it accepts the frame, it checks that the frame fits inside the buffer that was programmed for it.

Two buffers can be programmed. In dual mode the sequencer switches to the other buffer after each accepted frame. Each buffer has its own completion bit, which is cleared each time the controller is switched on.

A frame that does not fit raises a sync error and stops the sequencer until the controller is switched off and on again. Pixel drawing is left to the logic downstream.

Top module: `fbseq_top`

## Requirements
- R1: The depth code is bits 14:12 of the header word. Code 1 gives 2 bpp, code 2 gives 4 bpp, code 3 gives 8 bpp, and codes 4 to 7 give 16 bpp. Code 0 completes the frame with `skip`=1, leaves `buf_done` and `active_buf` unchanged, and is not checked against the buffer size. All other header bits are ignored.
- R2: In modes 0 and 3 (`pal_mode`), pixel data starts at the buffer top plus 0x200 for codes 3 to 7, and plus 0x20 for codes 1 and 2. In mode 2 no header is read: the last fetched header sets the depth, and pixel data starts at the buffer top.
- R3: In mode 1, a frame start raises `done` with `skip`=1 on the next edge. No read is issued and `buf_done` does not change.
- R4: `pal_loaded` is cleared when `lcd_on` rises. It is set when the first header read after that completes.
- R5: A frame overflows when the data offset plus width×height×bpp/8 exceeds (bottom − top + 2) of the active buffer. Equality is still accepted. On overflow, `sync_err`=1, `running`=0 and `skip`=1, and later frame starts are ignored. `sync_err` clears when `lcd_on` goes low.
- R6: If subpanel bit 31 is clear, lines run from 0 up to (but not including) the height. If bit 31 is set, bits 25:16 give the first line when bit 29 is set. When bit 29 is clear, bits 25:16 replace the end line.
- R7: `line_step` equals width×bpp/8. `line_addr` equals `pix_start` plus `line_step` times `first_line`.
- R8: An accepted frame sets bit `active_buf` of `buf_done`. With `dual`=1, `active_buf` toggles after every accepted frame. With `dual`=0 it stays 0. The rising edge of `lcd_on` resets `active_buf` to 0.
- R9: `color12` is 1 exactly when an accepted frame is 16 bpp and `tft`=0.
- R10: `done` is a one-cycle pulse, counted in clock edges from the edge that samples `frame_start`. It comes on that edge in mode 1, one edge later in mode 2, and one edge after read data is accepted in a fetching mode. A frame start while `running`=0 produces no `done` and no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lcd_on | input | 1 | Controller enable level |
| frame_start | input | 1 | One-cycle frame start pulse |
| pal_mode | input | 2 | Palette-load mode (0..3) |
| tft | input | 1 | Active-matrix panel |
| dual | input | 1 | Alternate between two buffers |
| width_m1 | input | 10 | Panel width minus 1 |
| height_m1 | input | 10 | Panel height minus 1 |
| subpanel | input | 32 | Subpanel control word |
| buf0_top | input | AW | Buffer 0 first byte address |
| buf0_bot | input | AW | Buffer 0 end address |
| buf1_top | input | AW | Buffer 1 first byte address |
| buf1_bot | input | AW | Buffer 1 end address |
| rd_req | output | 1 | Header read request, held until data |
| rd_addr | output | AW | Header read address |
| rd_data | input | 16 | Header read data |
| rd_valid | input | 1 | Read data valid |
| done | output | 1 | Frame evaluation complete pulse |
| skip | output | 1 | Frame produced no output |
| bpp | output | 5 | Bits per pixel |
| color12 | output | 1 | 16-bit pixels carry 12-bit colour |
| pix_start | output | AW | Pixel data start address |
| line_step | output | 16 | Bytes per line |
| first_line | output | 11 | First line shown |
| last_line | output | 11 | Line after the last shown |
| line_addr | output | AW | Address of first shown line |
| buf_done | output | 2 | Per-buffer completion bits |
| active_buf | output | 1 | Buffer used by the next frame |
| pal_loaded | output | 1 | Header fetched since enable |
| sync_err | output | 1 | Frame overflow error |
| running | output | 1 | Sequencer accepting frames |

## Verification
The read model returns data on the first falling edge after it sees `rd_req`, so the timing of `done` is fixed for each mode:

| Mode | Falling edges after the `frame_start` pulse is driven |
|---|---|
| 1 | 1 |
| 2 | 2 |
| 0 or 3 | 3 |

Each frame task records the falling edge on which `done` was seen and compares it with that count. The result outputs are registered on the same edge as `done` and then hold, so they are sampled on the falling edge that shows `done`. Frames that should produce nothing are watched for eight cycles. During that time `done` must stay low, the read counter must not move, and the buffer bits must not change.

// File: rtl/fbseq_pkg.sv
package fbseq_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_EVAL} seq_st_e;

  localparam logic [1:0] MODE_NO_FETCH = 2'd1;
  localparam logic [1:0] MODE_PIX_ONLY = 2'd2;

  localparam int HDR_CODE_LSB = 12;
  localparam logic [31:0] OFS_SMALL = 32'h20;
  localparam logic [31:0] OFS_LARGE = 32'h200;

  function automatic logic [4:0] depth_bits(input logic [2:0] code);
    case (code)
      3'd1:    depth_bits = 5'd2;
      3'd2:    depth_bits = 5'd4;
      3'd3:    depth_bits = 5'd8;
      3'd0:    depth_bits = 5'd0;
      default: depth_bits = 5'd16;
    endcase
  endfunction

  function automatic logic [31:0] data_offset(input logic [2:0] code, input logic no_pal);
    if (no_pal)          data_offset = 32'd0;
    else if (code >= 3'd3) data_offset = OFS_LARGE;
    else                 data_offset = OFS_SMALL;
  endfunction

  function automatic logic [31:0] frame_bytes(input logic [31:0] w, input logic [31:0] h,
                                              input logic [4:0] b);
    frame_bytes = (w * h * {27'd0, b}) >> 3;
  endfunction

  function automatic logic [31:0] bytes_per_line(input logic [31:0] w, input logic [4:0] b);
    bytes_per_line = (w * {27'd0, b}) >> 3;
  endfunction

endpackage

// File: rtl/fbseq_hdr_fetch.sv
module fbseq_hdr_fetch #(
  parameter int AW = 24,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          abort,
  input  logic [AW-1:0] addr,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  input  logic          rd_valid,
  output logic          hdr_ok,
  output logic [DW-1:0] hdr
);

  logic busy_q;
  logic [AW-1:0] addr_q;

  assign rd_req  = busy_q;
  assign rd_addr = addr_q;
  assign hdr_ok  = busy_q & rd_valid & ~abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      addr_q <= '0;
      hdr    <= '0;
    end else begin
      if (abort) begin
        busy_q <= 1'b0;
      end else if (go) begin
        busy_q <= 1'b1;
        addr_q <= addr;
      end else if (hdr_ok) begin
        busy_q <= 1'b0;
        hdr    <= rd_data;
      end
    end
  end

  p_req_holds_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_valid && !abort) |=> (rd_req && $stable(rd_addr)));

endmodule

// File: rtl/fbseq_geom.sv
module fbseq_geom
  import fbseq_pkg::*;
#(
  parameter int AW = 24,
  parameter int LW = 10
) (
  input  logic [2:0]    code,
  input  logic          no_pal,
  input  logic          tft,
  input  logic [LW-1:0] width_m1,
  input  logic [LW-1:0] height_m1,
  input  logic [31:0]   subpanel,
  input  logic [AW-1:0] top,
  input  logic [AW-1:0] bot,
  output logic [4:0]    bpp,
  output logic          unsupported,
  output logic          overflow,
  output logic          color12,
  output logic [AW-1:0] pix_start,
  output logic [15:0]   step,
  output logic [LW:0]   first_line,
  output logic [LW:0]   last_line,
  output logic [AW-1:0] line_addr
);

  localparam int SP_EN = 31;
  localparam int SP_SEL_START = 29;
  localparam int SP_LINE_LSB = 16;

  logic [31:0] w32, h32, ofs, need, room, step32;
  logic [AW-1:0] size;

  always_comb begin
    w32     = 32'(width_m1) + 32'd1;
    h32     = 32'(height_m1) + 32'd1;
    bpp     = depth_bits(code);
    unsupported = (bpp == 5'd0);
    ofs     = data_offset(code, no_pal);
    size    = bot - top;
    need    = ofs + frame_bytes(w32, h32, bpp);
    room    = 32'(size) + 32'd2;
    overflow = !unsupported && (need > room);
    color12 = (bpp == 5'd16) && !tft;
    step32  = bytes_per_line(w32, bpp);
    step    = step32[15:0];
    pix_start = top + AW'(ofs);
    first_line = '0;
    last_line  = h32[LW:0];
    if (subpanel[SP_EN]) begin
      if (subpanel[SP_SEL_START]) first_line = {1'b0, subpanel[SP_LINE_LSB +: LW]};
      else                        last_line  = {1'b0, subpanel[SP_LINE_LSB +: LW]};
    end
    line_addr = pix_start + AW'(step32 * 32'(first_line));
  end

endmodule

// File: rtl/fbseq_top.sv
module fbseq_top
  import fbseq_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 16,
  parameter int LW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lcd_on,
  input  logic          frame_start,
  input  logic [1:0]    pal_mode,
  input  logic          tft,
  input  logic          dual,
  input  logic [LW-1:0] width_m1,
  input  logic [LW-1:0] height_m1,
  input  logic [31:0]   subpanel,
  input  logic [AW-1:0] buf0_top,
  input  logic [AW-1:0] buf0_bot,
  input  logic [AW-1:0] buf1_top,
  input  logic [AW-1:0] buf1_bot,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  input  logic          rd_valid,
  output logic          done,
  output logic          skip,
  output logic [4:0]    bpp,
  output logic          color12,
  output logic [AW-1:0] pix_start,
  output logic [15:0]   line_step,
  output logic [LW:0]   first_line,
  output logic [LW:0]   last_line,
  output logic [AW-1:0] line_addr,
  output logic [1:0]    buf_done,
  output logic          active_buf,
  output logic          pal_loaded,
  output logic          sync_err,
  output logic          running
);

  seq_st_e st_q;
  logic lcd_q, en_rise, start_ok, go_fetch, go_eval, skip_now, hdr_ok;
  logic [DW-1:0] hdr;
  logic [AW-1:0] cur_top, cur_bot;
  logic g_unsup, g_ovf, g_c12;
  logic [4:0] g_bpp;
  logic [AW-1:0] g_pix, g_laddr;
  logic [15:0] g_step;
  logic [LW:0] g_first, g_last;

  assign en_rise  = lcd_on & ~lcd_q;
  assign start_ok = (st_q == ST_IDLE) & frame_start & running & lcd_on;
  assign skip_now = start_ok & (pal_mode == MODE_NO_FETCH);
  assign go_eval  = start_ok & (pal_mode == MODE_PIX_ONLY);
  assign go_fetch = start_ok & ~skip_now & ~go_eval;
  assign cur_top  = active_buf ? buf1_top : buf0_top;
  assign cur_bot  = active_buf ? buf1_bot : buf0_bot;

  fbseq_hdr_fetch #(.AW(AW), .DW(DW)) u_fetch (
    .clk(clk), .rst_n(rst_n), .go(go_fetch), .abort(~lcd_on), .addr(cur_top),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
    .hdr_ok(hdr_ok), .hdr(hdr));

  fbseq_geom #(.AW(AW), .LW(LW)) u_geom (
    .code(hdr[HDR_CODE_LSB +: 3]), .no_pal(pal_mode == MODE_PIX_ONLY), .tft(tft),
    .width_m1(width_m1), .height_m1(height_m1), .subpanel(subpanel),
    .top(cur_top), .bot(cur_bot), .bpp(g_bpp), .unsupported(g_unsup),
    .overflow(g_ovf), .color12(g_c12), .pix_start(g_pix), .step(g_step),
    .first_line(g_first), .last_line(g_last), .line_addr(g_laddr));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      lcd_q <= 1'b0;
      running <= 1'b0;
      sync_err <= 1'b0;
      pal_loaded <= 1'b0;
      buf_done <= '0;
      active_buf <= 1'b0;
      done <= 1'b0;
      skip <= 1'b0;
      bpp <= '0;
      color12 <= 1'b0;
      pix_start <= '0;
      line_step <= '0;
      first_line <= '0;
      last_line <= '0;
      line_addr <= '0;
    end else begin
      lcd_q <= lcd_on;
      done <= 1'b0;
      if (!lcd_on) begin
        running <= 1'b0;
        sync_err <= 1'b0;
        st_q <= ST_IDLE;
      end else if (en_rise) begin
        running <= 1'b1;
        pal_loaded <= 1'b0;
        buf_done <= '0;
        active_buf <= 1'b0;
        st_q <= ST_IDLE;
      end else begin
        if (hdr_ok) pal_loaded <= 1'b1;
        case (st_q)
          ST_IDLE: begin
            if (skip_now) begin
              done <= 1'b1;
              skip <= 1'b1;
            end else if (go_eval)  st_q <= ST_EVAL;
            else if (go_fetch)     st_q <= ST_FETCH;
          end
          ST_FETCH: if (hdr_ok) st_q <= ST_EVAL;
          ST_EVAL: begin
            st_q <= ST_IDLE;
            done <= 1'b1;
            skip <= g_unsup | g_ovf;
            bpp <= g_bpp;
            color12 <= g_c12;
            pix_start <= g_pix;
            line_step <= g_step;
            first_line <= g_first;
            last_line <= g_last;
            line_addr <= g_laddr;
            if (g_ovf) begin
              sync_err <= 1'b1;
              running <= 1'b0;
            end else if (!g_unsup) begin
              buf_done[active_buf] <= 1'b1;
              if (dual) active_buf <= ~active_buf;
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  p_depth_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !skip) |-> (bpp == 5'd2 || bpp == 5'd4 || bpp == 5'd8 || bpp == 5'd16));
  p_mode1_noread_r3: assert property (@(posedge clk) disable iff (!rst_n)
    skip_now |=> !rd_req);
  p_pal_after_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pal_loaded) |-> $past(rd_req && rd_valid));
  p_sync_halts_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_err) |-> !running);
  p_skip_keeps_bufs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && skip) |-> (buf_done == $past(buf_done)));
  p_dual_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !skip && $past(dual) && $past(lcd_on)) |-> (active_buf != $past(active_buf)));
  p_color12_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && color12) |-> (bpp == 5'd16));
  p_read_needs_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> running);
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/fbseq_top_tb_top.sv
module fbseq_top_tb_top;
  localparam int AW = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lcd_on = 1'b0, frame_start = 1'b0, tft = 1'b0, dual = 1'b0;
  logic [1:0] pal_mode = 2'd0;
  logic [9:0] width_m1 = 10'd15, height_m1 = 10'd7;
  logic [31:0] subpanel = 32'd0;
  logic [AW-1:0] buf0_top = 24'h1000, buf0_bot = 24'h1400;
  logic [AW-1:0] buf1_top = 24'h8000, buf1_bot = 24'h8400;
  logic rd_req, rd_valid = 1'b0;
  logic [AW-1:0] rd_addr;
  logic [15:0] rd_data = 16'd0, hdr0 = 16'h3000, hdr1 = 16'h2000;
  logic done, skip, color12, active_buf, pal_loaded, sync_err, running;
  logic [4:0] bpp;
  logic [AW-1:0] pix_start, line_addr;
  logic [15:0] line_step;
  logic [10:0] first_line, last_line;
  logic [1:0] buf_done;
  int checks = 0, fails = 0, reads = 0;

  always #4 clk = ~clk;

  fbseq_top #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .lcd_on(lcd_on), .frame_start(frame_start),
    .pal_mode(pal_mode), .tft(tft), .dual(dual), .width_m1(width_m1),
    .height_m1(height_m1), .subpanel(subpanel), .buf0_top(buf0_top),
    .buf0_bot(buf0_bot), .buf1_top(buf1_top), .buf1_bot(buf1_bot),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
    .done(done), .skip(skip), .bpp(bpp), .color12(color12), .pix_start(pix_start),
    .line_step(line_step), .first_line(first_line), .last_line(last_line),
    .line_addr(line_addr), .buf_done(buf_done), .active_buf(active_buf),
    .pal_loaded(pal_loaded), .sync_err(sync_err), .running(running));

  always @(negedge clk) begin
    if (rd_req) reads++;
    rd_valid = rd_req;
    rd_data  = (rd_addr == buf1_top) ? hdr1 : hdr0;
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic restart();
    lcd_on = 1'b0;
    @(negedge clk);
    lcd_on = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_frame(output int lat);
    lat = 0;
    frame_start = 1'b1;
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk);
      if (i == 1) frame_start = 1'b0;
      if (done && lat == 0) lat = i;
    end
  endtask

  task automatic t_reset();
    chk("R10 reset done", done, 0);
    chk("R5 reset sync_err", sync_err, 0);
    chk("R8 reset buf_done", buf_done, 0);
    chk("R4 reset pal_loaded", pal_loaded, 0);
    chk("R10 reset running", running, 0);
  endtask

  task automatic t_idle_ignored();
    int lat, r0;
    lcd_on = 1'b0;
    @(negedge clk);
    r0 = reads;
    run_frame(lat);
    chk("R10 no done while stopped", lat, 0);
    chk("R10 no read while stopped", reads - r0, 0);
  endtask

  task automatic t_depth8();
    int lat;
    hdr0 = 16'h3000; pal_mode = 2'd0; dual = 1'b0; subpanel = 0;
    width_m1 = 15; height_m1 = 7;
    restart();
    chk("R4 pal_loaded cleared on enable", pal_loaded, 0);
    run_frame(lat);
    chk("R10 fetch latency", lat, 3);
    chk("R1 bpp code3", bpp, 8);
    chk("R2 offset 0x200", pix_start, 24'h1200);
    chk("R7 step", line_step, 16);
    chk("R6 default first", first_line, 0);
    chk("R6 default last", last_line, 8);
    chk("R7 line_addr", line_addr, 24'h1200);
    chk("R8 buf_done bit0", buf_done, 2'b01);
    chk("R8 single stays", active_buf, 0);
    chk("R4 pal_loaded", pal_loaded, 1);
    chk("R9 color12 off", color12, 0);
  endtask

  task automatic t_depth2_start();
    int lat;
    hdr0 = 16'h9FFF & 16'h9FFF; hdr0 = 16'h1000;
    subpanel = 32'h8000_0000 | 32'h2000_0000 | (32'd3 << 16);
    restart();
    run_frame(lat);
    chk("R1 bpp code1", bpp, 2);
    chk("R2 offset 0x20", pix_start, 24'h1020);
    chk("R6 first from subpanel", first_line, 3);
    chk("R6 last kept", last_line, 8);
    chk("R7 line_addr start line", line_addr, 24'h102C);
  endtask

  task automatic t_depth16_height();
    int lat;
    hdr0 = 16'h5000; tft = 1'b0;
    subpanel = 32'h8000_0000 | (32'd5 << 16);
    restart();
    run_frame(lat);
    chk("R1 bpp code5", bpp, 16);
    chk("R9 color12 non-tft", color12, 1);
    chk("R6 end from subpanel", last_line, 5);
    chk("R6 first zero", first_line, 0);
    chk("R7 step 16bpp", line_step, 32);
    tft = 1'b1;
    run_frame(lat);
    chk("R9 color12 tft", color12, 0);
    tft = 1'b0; subpanel = 0;
  endtask

  task automatic t_dual();
    int lat;
    hdr0 = 16'h3000; hdr1 = 16'h2000; dual = 1'b1;
    restart();
    run_frame(lat);
    chk("R8 dual A buf_done", buf_done, 2'b01);
    chk("R8 dual A toggles", active_buf, 1);
    run_frame(lat);
    chk("R1 dual B bpp", bpp, 4);
    chk("R2 dual B pix", pix_start, 24'h8020);
    chk("R8 dual B buf_done", buf_done, 2'b11);
    chk("R8 dual B toggles back", active_buf, 0);
    dual = 1'b0;
    restart();
    chk("R8 enable clears buf_done", buf_done, 0);
  endtask

  task automatic t_mode2();
    int lat, r0;
    hdr0 = 16'h3000; pal_mode = 2'd0;
    restart();
    run_frame(lat);
    pal_mode = 2'd2; hdr0 = 16'h1000;
    r0 = reads;
    run_frame(lat);
    chk("R10 mode2 latency", lat, 2);
    chk("R2 mode2 no read", reads - r0, 0);
    chk("R2 mode2 pix at top", pix_start, 24'h1000);
    chk("R2 mode2 stale depth", bpp, 8);
    pal_mode = 2'd0; hdr0 = 16'h3000;
  endtask

  task automatic t_mode1();
    int lat, r0;
    restart();
    pal_mode = 2'd1;
    r0 = reads;
    run_frame(lat);
    chk("R3 mode1 latency", lat, 1);
    chk("R3 mode1 skip", skip, 1);
    chk("R3 mode1 no read", reads - r0, 0);
    chk("R3 mode1 buf_done", buf_done, 0);
    pal_mode = 2'd0;
  endtask

  task automatic t_code0();
    int lat;
    hdr0 = 16'h8FFF;
    restart();
    run_frame(lat);
    chk("R1 code0 done", lat, 3);
    chk("R1 code0 skip", skip, 1);
    chk("R1 code0 buf_done", buf_done, 0);
    chk("R1 code0 active", active_buf, 0);
    chk("R5 code0 no sync", sync_err, 0);
    hdr0 = 16'h3000;
  endtask

  task automatic t_overflow();
    int lat, r0;
    hdr0 = 16'h3000; width_m1 = 1; height_m1 = 256;
    restart();
    run_frame(lat);
    chk("R5 exact fit accepted", sync_err, 0);
    chk("R5 exact fit skip", skip, 0);
    height_m1 = 257;
    run_frame(lat);
    chk("R5 overflow sync_err", sync_err, 1);
    chk("R5 overflow stops", running, 0);
    chk("R5 overflow skip", skip, 1);
    chk("R5 overflow buf_done kept", buf_done, 2'b01);
    r0 = reads;
    run_frame(lat);
    chk("R5 frames ignored after error", lat, 0);
    chk("R5 no read after error", reads - r0, 0);
    lcd_on = 1'b0;
    @(negedge clk);
    chk("R5 sync_err cleared", sync_err, 0);
    width_m1 = 15; height_m1 = 7;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_idle_ignored();
    t_depth8();
    t_depth2_start();
    t_depth16_height();
    t_dual();
    t_mode2();
    t_mode1();
    t_code0();
    t_overflow();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule